// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects interrupt requests from a set of internal sources and a small group of external lines. It presents the processor with the highest pending priority level (1 to 7, 0 meaning nothing pending) and the vector number of the single winning request. Each internal source carries a programmed level and a programmed rank within that level. External line k sits at the fixed level k+1. It always outranks internal sources at its level.

Arbitration has two stages. The level decides first, then the rank within the level, and a tie on both goes to the lower source index. Every source has its own vector: a base offset plus the source index. A per-source mask and a global mask-all input remove requests from arbitration. A hardware acknowledge names a level and returns the best source pending at exactly that level. A software acknowledge returns the overall winner. When nothing qualifies, either acknowledge returns a spurious vector. A purely combinational wake output rises from any unmasked pending request, so it works with the clock stopped.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, `irq_level_o` is 0, `irq_vec_o` equals `SPUR_VEC` (default 24) and `ack_valid_o` is 0.
- R2: An internal source whose 3-bit level field is 0 never requests, whatever its request input.
- R3: Among qualifying requests the one with the highest level wins, and `irq_level_o` shows that level.
- R4: At equal level, the higher 4-bit rank field wins. Equal level and rank go to the lower source index.
- R5: External line k (bit k of `ext_req_i`) has level k+1 and beats every internal source at that level.
- R6: The vector is `VEC_BASE` (default 64) plus the source index. Internal source i has index i, and external line k has index `N_INT`+k (default 56+k).
- R7: Setting bit j of `mask_i` removes source index j from arbitration, from wake and from both acknowledges.
- R8: While `mask_all_i` is 1, nothing is pending: level 0, spurious vector, `wake_o` low.
- R9: `wake_o` is high in the same cycle as any qualifying request, without a clock edge.
- R10: A software acknowledge (`sw_ack_i` high at an edge) makes `ack_valid_o` 1 for the next cycle, with `ack_vec_o` equal to the overall winner's vector, or `SPUR_VEC` if nothing is pending. With no acknowledge, `ack_valid_o` is 0.
- R11: A hardware acknowledge (`hw_ack_i` with level `hw_ack_lvl_i`) returns the best qualifying source at exactly that level, or `SPUR_VEC` if there is none. It takes precedence over a simultaneous software acknowledge.
- R12: `irq_level_o` and `irq_vec_o` reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_req_i | input | N_INT | Internal request lines |
| int_lvl_i | input | 3*N_INT | Level of each internal source, 3 bits per source |
| int_rank_i | input | PW*N_INT | Rank within the level of each internal source |
| ext_req_i | input | N_EXT | External request lines, fixed levels |
| mask_i | input | N_INT+N_EXT | Per-source mask by source index |
| mask_all_i | input | 1 | Global mask |
| hw_ack_i | input | 1 | Hardware acknowledge strobe |
| hw_ack_lvl_i | input | 3 | Level being acknowledged |
| sw_ack_i | input | 1 | Software acknowledge strobe |
| wake_o | output | 1 | Combinational wake request |
| irq_level_o | output | 3 | Highest pending level, registered |
| irq_vec_o | output | VW | Vector of current winner, registered |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_vec_o | output | VW | Acknowledge result vector |

## Verification
The wake output is due in the same cycle as the stimulus, so the bench checks it a moment after driving the inputs on the falling edge. The level and vector outputs, and any acknowledge result, are due after exactly one rising edge. The bench therefore drives on a falling edge, lets one rising edge pass, and compares on the next falling edge against a model that scores every source with a packed key computed in the bench. Acknowledge strobes are dropped on that same falling edge, so each strobe covers exactly one edge.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   localparam int LVL_W   = 3;
   localparam int MAX_LVL = 7;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/lvl_irq_qualify.sv
module lvl_irq_qualify
   import lvl_irq_pkg::*;
#(
   parameter int N_INT = 56,
   parameter int N_EXT = 7,
   parameter int PW    = 4,
   parameter int NSRC  = N_INT + N_EXT,
   parameter int IW    = $clog2(NSRC),
   parameter int KW    = LVL_W + 1 + PW + IW
) (
   input  logic [N_INT-1:0]       int_req_i,
   input  logic [N_INT*LVL_W-1:0] int_lvl_i,
   input  logic [N_INT*PW-1:0]    int_rank_i,
   input  logic [N_EXT-1:0]       ext_req_i,
   input  logic [NSRC-1:0]        mask_i,
   input  logic                   mask_all_i,
   output logic [NSRC-1:0]        valid_o,
   output logic [NSRC*KW-1:0]     key_o
);
   // key = {level, external flag, rank, inverted index}: larger key wins
   for (genvar i = 0; i < N_INT; i++) begin : g_int
      lvl_t lv;
      assign lv = int_lvl_i[i*LVL_W +: LVL_W];
      assign valid_o[i] = int_req_i[i] & ~mask_i[i] & ~mask_all_i & (lv != '0);
      assign key_o[i*KW +: KW] = {lv, 1'b0, int_rank_i[i*PW +: PW], ~IW'(i)};
   end

   for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      localparam int IDX = N_INT + k;
      assign valid_o[IDX] = ext_req_i[k] & ~mask_i[IDX] & ~mask_all_i;
      assign key_o[IDX*KW +: KW] = {LVL_W'(k + 1), 1'b1, {PW{1'b0}}, ~IW'(IDX)};
   end
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
   import lvl_irq_pkg::*;
#(
   parameter int NSRC = 63,
   parameter int IW   = 6,
   parameter int KW   = 14
) (
   input  logic [NSRC-1:0]    valid_i,
   input  logic [NSRC*KW-1:0] key_i,
   input  logic               filt_en_i,
   input  lvl_t               filt_lvl_i,
   output logic               found_o,
   output logic [IW-1:0]      idx_o,
   output lvl_t               lvl_o
);
   logic [KW-1:0] best;

   always_comb begin
      best    = '0;
      found_o = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         logic [KW-1:0] k;
         logic          ok;
         k  = key_i[i*KW +: KW];
         ok = valid_i[i] && (!filt_en_i || (k[KW-1 -: LVL_W] == filt_lvl_i));
         if (ok && (!found_o || (k > best))) begin
            best    = k;
            found_o = 1'b1;
         end
      end
      idx_o = ~best[IW-1:0];
      lvl_o = found_o ? best[KW-1 -: LVL_W] : '0;
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int N_INT    = 56,
   parameter int N_EXT    = 7,
   parameter int PW       = 4,
   parameter int VW       = 8,
   parameter int VEC_BASE = 64,
   parameter int SPUR_VEC = 24
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [N_INT-1:0]       int_req_i,
   input  logic [N_INT*3-1:0]     int_lvl_i,
   input  logic [N_INT*PW-1:0]    int_rank_i,
   input  logic [N_EXT-1:0]       ext_req_i,
   input  logic [N_INT+N_EXT-1:0] mask_i,
   input  logic                   mask_all_i,
   input  logic                   hw_ack_i,
   input  logic [2:0]             hw_ack_lvl_i,
   input  logic                   sw_ack_i,
   output logic                   wake_o,
   output logic [2:0]             irq_level_o,
   output logic [VW-1:0]          irq_vec_o,
   output logic                   ack_valid_o,
   output logic [VW-1:0]          ack_vec_o
);
   localparam int NSRC = N_INT + N_EXT;
   localparam int IW   = $clog2(NSRC);
   localparam int KW   = LVL_W + 1 + PW + IW;

   if (N_EXT < 1 || N_EXT > MAX_LVL) begin : g_bad_ext
      $error("N_EXT must lie in 1..7");
   end
   if (N_INT < 1) begin : g_bad_int
      $error("N_INT must be at least 1");
   end
   if (VEC_BASE + NSRC > (1 << VW)) begin : g_bad_vw
      $error("vector range exceeds VW bits");
   end
   if (SPUR_VEC >= VEC_BASE && SPUR_VEC < VEC_BASE + NSRC) begin : g_bad_spur
      $error("spurious vector overlaps a source vector");
   end

   logic [NSRC-1:0]    valid;
   logic [NSRC*KW-1:0] keys;
   logic               g_found, h_found;
   logic [IW-1:0]      g_idx, h_idx;
   lvl_t               g_lvl, h_lvl;

   lvl_irq_qualify #(.N_INT(N_INT), .N_EXT(N_EXT), .PW(PW)) u_qual (
      .int_req_i (int_req_i),
      .int_lvl_i (int_lvl_i),
      .int_rank_i(int_rank_i),
      .ext_req_i (ext_req_i),
      .mask_i    (mask_i),
      .mask_all_i(mask_all_i),
      .valid_o   (valid),
      .key_o     (keys)
   );

   lvl_irq_arb #(.NSRC(NSRC), .IW(IW), .KW(KW)) u_arb_all (
      .valid_i   (valid),
      .key_i     (keys),
      .filt_en_i (1'b0),
      .filt_lvl_i('0),
      .found_o   (g_found),
      .idx_o     (g_idx),
      .lvl_o     (g_lvl)
   );

   lvl_irq_arb #(.NSRC(NSRC), .IW(IW), .KW(KW)) u_arb_lvl (
      .valid_i   (valid),
      .key_i     (keys),
      .filt_en_i (1'b1),
      .filt_lvl_i(hw_ack_lvl_i),
      .found_o   (h_found),
      .idx_o     (h_idx),
      .lvl_o     (h_lvl)
   );

   assign wake_o = |valid;

   function automatic logic [VW-1:0] to_vec(input logic f, input logic [IW-1:0] idx);
      return f ? (VW'(VEC_BASE) + VW'(idx)) : VW'(SPUR_VEC);
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_level_o <= '0;
         irq_vec_o   <= VW'(SPUR_VEC);
         ack_valid_o <= 1'b0;
         ack_vec_o   <= VW'(SPUR_VEC);
      end else begin
         irq_level_o <= g_lvl;
         irq_vec_o   <= to_vec(g_found, g_idx);
         ack_valid_o <= hw_ack_i | sw_ack_i;
         if (hw_ack_i) begin
            ack_vec_o <= to_vec(h_found && (h_lvl != '0), h_idx);
         end else if (sw_ack_i) begin
            ack_vec_o <= to_vec(g_found, g_idx);
         end
      end
   end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
   parameter int VW       = 8,
   parameter int VEC_BASE = 64,
   parameter int SPUR_VEC = 24
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          mask_all_i,
   input logic          hw_ack_i,
   input logic          sw_ack_i,
   input logic          wake_o,
   input logic [2:0]    irq_level_o,
   input logic [VW-1:0] irq_vec_o,
   input logic          ack_valid_o,
   input logic [VW-1:0] ack_vec_o
);
   logic past_ok;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   // R12
   lvl_follows_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> ((irq_level_o != 3'd0) == $past(wake_o)));
   // R8
   mask_all_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_all_i |=> (irq_level_o == 3'd0));
   // R1
   idle_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_level_o == 3'd0) |-> (irq_vec_o == VW'(SPUR_VEC)));
   // R6
   busy_vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_level_o != 3'd0) |-> (irq_vec_o >= VW'(VEC_BASE)));
   // R10
   ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_ack_i || sw_ack_i) |=> ack_valid_o);
   // R10
   no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hw_ack_i || sw_ack_i) |=> !ack_valid_o);
   // R10
   sw_ack_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_ack_i && !hw_ack_i) |=> (ack_vec_o == irq_vec_o));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.VW(VW), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mask_all_i (mask_all_i),
   .hw_ack_i   (hw_ack_i),
   .sw_ack_i   (sw_ack_i),
   .wake_o     (wake_o),
   .irq_level_o(irq_level_o),
   .irq_vec_o  (irq_vec_o),
   .ack_valid_o(ack_valid_o),
   .ack_vec_o  (ack_vec_o)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
   localparam int N_INT = 56;
   localparam int N_EXT = 7;
   localparam int NSRC  = N_INT + N_EXT;
   localparam int PW    = 4;
   localparam int VW    = 8;
   localparam int VBASE = 64;
   localparam int SPUR  = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_INT-1:0]    int_req = '0;
   logic [N_INT*3-1:0]  int_lvl = '0;
   logic [N_INT*PW-1:0] int_rank = '0;
   logic [N_EXT-1:0]    ext_req = '0;
   logic [NSRC-1:0]     mask = '0;
   logic                mask_all = 1'b0;
   logic                hw_ack = 1'b0;
   logic [2:0]          hw_lvl = '0;
   logic                sw_ack = 1'b0;
   logic                wake, ack_valid;
   logic [2:0]          irq_level;
   logic [VW-1:0]       irq_vec, ack_vec;

   always #10 clk = ~clk;

   lvl_irq_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .PW(PW), .VW(VW),
                  .VEC_BASE(VBASE), .SPUR_VEC(SPUR)) u_lvl_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .int_req_i(int_req), .int_lvl_i(int_lvl),
      .int_rank_i(int_rank), .ext_req_i(ext_req), .mask_i(mask),
      .mask_all_i(mask_all), .hw_ack_i(hw_ack), .hw_ack_lvl_i(hw_lvl),
      .sw_ack_i(sw_ack), .wake_o(wake), .irq_level_o(irq_level),
      .irq_vec_o(irq_vec), .ack_valid_o(ack_valid), .ack_vec_o(ack_vec));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // model: returns winning index or -1; lv gets its level
   function automatic int model(input bit filt, input int fl, output int lv);
      int best = -1;
      int bkey = -1;
      lv = 0;
      for (int i = 0; i < NSRC; i++) begin
         int l, e, p, key;
         bit ok;
         if (i < N_INT) begin
            l = int'(int_lvl[i*3 +: 3]);
            p = int'(int_rank[i*PW +: PW]);
            e = 0;
            ok = int_req[i] && l != 0;
         end else begin
            l = i - N_INT + 1;
            p = 0;
            e = 1;
            ok = ext_req[i-N_INT];
         end
         ok = ok && !mask[i] && !mask_all && (!filt || l == fl);
         key = (l << 11) | (e << 10) | (p << 6) | (63 - i);
         if (ok && key > bkey) begin
            bkey = key;
            best = i;
            lv = l;
         end
      end
      return best;
   endfunction

   function automatic int vec_of(input int idx);
      return (idx < 0) ? SPUR : VBASE + idx;
   endfunction

   // called at a falling edge with inputs already set
   task automatic step(input string tag, input bit h, input int hl, input bit s);
      int lv, hv, w, hw_w;
      hw_ack = h;
      hw_lvl = 3'(hl);
      sw_ack = s;
      w = model(0, 0, lv);
      hw_w = model(1, hl, hv);
      #1;
      check({tag, " R9 wake"}, int'(wake), int'(w >= 0));
      @(posedge clk);
      @(negedge clk);
      hw_ack = 0;
      sw_ack = 0;
      check({tag, " level"}, int'(irq_level), lv);
      check({tag, " vector"}, int'(irq_vec), vec_of(w));
      check({tag, " R10 ack_valid"}, int'(ack_valid), int'(h | s));
      if (h) check({tag, " R11 hw ack"}, int'(ack_vec), vec_of(hw_w));
      else if (s) check({tag, " R10 sw ack"}, int'(ack_vec), vec_of(w));
   endtask

   task automatic clear_all();
      int_req = '0; int_lvl = '0; int_rank = '0;
      ext_req = '0; mask = '0; mask_all = 1'b0;
   endtask

   task automatic set_src(input int i, input int l, input int p);
      int_lvl[i*3 +: 3] = 3'(l);
      int_rank[i*PW +: PW] = PW'(p);
      int_req[i] = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      check("R1 reset level", int'(irq_level), 0);
      check("R1 reset vector", int'(irq_vec), SPUR);
      check("R1 reset ack_valid", int'(ack_valid), 0);
      @(negedge clk);

      set_src(3, 0, 7);
      step("R2 level zero", 0, 0, 0);
      set_src(3, 2, 5);
      set_src(10, 5, 1);
      step("R3 higher level", 0, 0, 0);
      set_src(20, 5, 9);
      step("R4 higher rank", 0, 0, 0);
      set_src(20, 5, 1);
      step("R4 tie lower index", 0, 0, 0);
      ext_req[4] = 1'b1;
      step("R5 R6 external wins", 0, 0, 0);
      mask[N_INT+4] = 1'b1;
      step("R7 mask external", 0, 0, 0);
      step("R10 sw ack", 0, 0, 1);
      step("R11 hw ack level 2", 1, 2, 0);
      step("R11 hw ack empty level", 1, 6, 0);
      step("R11 hw over sw", 1, 2, 1);
      mask[3] = 1'b1;
      step("R7 masked hw ack", 1, 2, 0);
      mask_all = 1'b1;
      step("R8 mask all", 0, 0, 1);
      clear_all();
      step("R10 sw ack idle", 0, 0, 1);

      for (int it = 0; it < 400; it++) begin
         for (int i = 0; i < N_INT; i++) begin
            int_lvl[i*3 +: 3] = 3'($urandom_range(0, 7));
            int_rank[i*PW +: PW] = PW'($urandom_range(0, 15));
            int_req[i] = ($urandom_range(0, 9) == 0);
         end
         for (int k = 0; k < N_EXT; k++) ext_req[k] = ($urandom_range(0, 7) == 0);
         for (int j = 0; j < NSRC; j++) mask[j] = ($urandom_range(0, 3) == 0);
         mask_all = ($urandom_range(0, 15) == 0);
         // R3 R4 R5 R6 R12 under random load
         step("R12 random", $urandom_range(0, 3) == 0, $urandom_range(0, 7),
              $urandom_range(0, 3) == 0);
      end
      finish_run();
   end
endmodule